// File: doc/BRIEF.md
# Byte-Serial SPI Port with Write-Collision Detection

This block is a full-duplex synchronous serial port that moves one byte at a time, most significant bit first. The same shift register sends and receives. In master mode it generates the serial clock itself from a divided system clock. In slave mode it follows a serial clock from outside, and an optional active-low select input can gate it. A host loads the outgoing byte through a write strobe and collects the incoming byte from a separate holding register. Because that register is separate from the shift register, the following byte can start before the previous one has been read.

Status flags report a full holding register, an overrun and a dropped host write. An interrupt request rises at the end of every byte. The clock idle level, the edge that launches data and the master sample point are set by configuration inputs, and together they cover all four SPI modes.

Top module: `spi_xfer_port`

## Requirements
- R1: In master mode, a host write while the port is idle loads the byte and starts a transfer. Eight bits go out MSB first on `sdo` while eight are taken in from `sdi`, so a looped-back `sdo` gives back the same byte in `host_rdata`, with either sample setting (`cfg_smp_end`=0 samples mid-bit, 1 samples at the end of the bit).
- R2: The master half clock period is 2·4^`cfg_rate` system clocks (rate codes 0..3 give 2, 8, 32 and 128). `st_busy` rises at the clock edge that takes the write and falls exactly 16 half periods later.
- R3: While no master transfer runs, and after reset, `sck_o` equals `cfg_cpol`. With `cfg_cpha`=1 the first transition comes right after the write edge. With `cfg_cpha`=0 it comes one half period later. Every byte makes 16 transitions and ends at the idle level.
- R4: When a byte completes, it goes into `host_rdata`, and `st_full` and `irq` are set at the same clock edge.
- R5: A `host_rd` pulse clears `st_full`.
- R6: A new transfer may start while `st_full` is set. The held byte stays readable until the new byte lands, and it is replaced then if it was read in the meantime.
- R7: A host write while `st_busy` is high is dropped, and the byte in flight is unchanged. It sets `st_wcol`, which stays set until a `clr_wcol` pulse. After that pulse, an idle write is accepted again.
- R8: A byte that completes while `st_full` is still set leaves `host_rdata` unchanged and sets `st_ovf`. Reading does not clear `st_ovf`; only `clr_ovf` does.
- R9: `irq` stays set until a `clr_irq` pulse, and that pulse leaves `st_full` unchanged.
- R10: In slave mode the port exchanges a byte, MSB first, on 8 external clock cycles in both phases. With phase 0 it samples on the leading edge and shifts on the trailing edge. With phase 1 it shifts on the leading edge and samples on the trailing edge.
- R11: In slave mode with `cfg_sel_en`=1 and `sel_n` high, `sdo_oe` is low, clock edges have no effect, and the bit count returns to zero, so a partial byte is abandoned and `st_busy` falls.
- R12: Synchronous reset clears `st_busy`, `st_full`, `st_wcol`, `st_ovf` and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_master | input | 1 | 1 = master (drives clock), 0 = slave |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0 = data launched before the leading edge, 1 = launched on the leading edge |
| cfg_smp_end | input | 1 | Master only: 1 samples input at the end of the bit time |
| cfg_rate | input | 2 | Master clock rate select |
| cfg_sel_en | input | 1 | Slave only: honour `sel_n` |
| host_wr | input | 1 | Host write strobe for the transmit byte |
| host_wdata | input | W | Transmit byte |
| host_rd | input | 1 | Host read strobe, clears the full flag |
| host_rdata | output | W | Received byte holding register |
| clr_wcol | input | 1 | Clears the write-collision flag |
| clr_ovf | input | 1 | Clears the overrun flag |
| clr_irq | input | 1 | Clears the interrupt request |
| st_busy | output | 1 | Transfer in progress |
| st_full | output | 1 | Holding register has an unread byte |
| st_wcol | output | 1 | A host write was dropped |
| st_ovf | output | 1 | A received byte was lost |
| irq | output | 1 | Byte-complete interrupt request |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |
| sel_n | input | 1 | Slave select, active low |

## Verification
In master mode, `st_busy` rises at the edge that takes the write, and every result lands exactly 16 half periods later: the holding register, `st_full` and `irq` all change at that edge. The bench therefore samples on falling edges half a cycle before and half a cycle after that edge, and it counts `sck_o` transitions on each falling edge over the whole window. Flag and collision effects of a host strobe appear one edge after the strobe and are checked on the next falling edge. In slave mode the inputs pass through a two-stage synchronizer, so the bench spaces its external clock edges eight system clocks apart and reads `sdo` and the status only after that margin.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

   // Per-boundary actions applied to the shift register
   typedef struct packed {
      logic cap;     // take the input bit
      logic shift;   // move the register by one position
      logic last;    // the byte is complete at this boundary
   } bit_ev_t;

   // Half period of the master clock, in system clocks
   function automatic int unsigned half_len(input int unsigned base,
                                            input int unsigned step_log2,
                                            input logic [1:0]  sel);
      return base << (step_log2 * int'(sel));
   endfunction

endpackage

// File: rtl/spi_sck_div.sv
module spi_sck_div #(
   parameter int unsigned BASE_HALF = 2,
   parameter int unsigned STEP_LOG2 = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       restart,
   input  logic       run,
   input  logic [1:0] sel,
   output logic       tick
);
   import spi_port_pkg::*;

   localparam int unsigned MAX_HALF = BASE_HALF << (3 * STEP_LOG2);
   localparam int unsigned CNT_W    = $clog2(MAX_HALF);

   if (BASE_HALF < 2) begin : g_bad_base
      $error("spi_sck_div: BASE_HALF must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;

   assign lim  = CNT_W'(half_len(BASE_HALF, STEP_LOG2, sel) - 1);
   assign tick = run && (cnt_q == lim);

   always_ff @(posedge clk) begin
      if (rst || restart || !run || tick) cnt_q <= '0;
      else                                cnt_q <= cnt_q + CNT_W'(1);
   end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
   parameter int unsigned W = 8
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   load,
   input  logic [W-1:0]           load_data,
   input  spi_port_pkg::bit_ev_t  ev,
   input  logic                   in_bit,
   output logic                   out_bit,
   output logic [W-1:0]           word_out
);
   logic [W-1:0] sr_q;
   logic         held_q;
   logic         bit_in;

   assign bit_in   = ev.cap ? in_bit : held_q;
   assign out_bit  = sr_q[W-1];
   assign word_out = {sr_q[W-2:0], bit_in};

   always_ff @(posedge clk) begin
      if (rst) begin
         sr_q   <= '0;
         held_q <= 1'b0;
      end else begin
         if (ev.cap) held_q <= in_bit;
         if (load)          sr_q <= load_data;
         else if (ev.shift) sr_q <= {sr_q[W-2:0], bit_in};
      end
   end
endmodule

// File: rtl/spi_rx_hold.sv
module spi_rx_hold #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         done,
   input  logic [W-1:0] word_in,
   input  logic         rd,
   input  logic         collide,
   input  logic         clr_wcol,
   input  logic         clr_ovf,
   input  logic         clr_irq,
   output logic [W-1:0] rdata,
   output logic         full,
   output logic         ovf,
   output logic         wcol,
   output logic         irq
);
   logic [W-1:0] buf_q;
   logic         full_q, ovf_q, wcol_q, irq_q;
   logic         full_eff;

   assign full_eff = full_q & ~rd;

   always_ff @(posedge clk) begin
      if (rst) begin
         buf_q  <= '0;
         full_q <= 1'b0;
         ovf_q  <= 1'b0;
         wcol_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         if (done && !full_eff) buf_q <= word_in;
         full_q <= done | full_eff;
         ovf_q  <= (done & full_eff) | (ovf_q & ~clr_ovf);
         irq_q  <= done | (irq_q & ~clr_irq);
         wcol_q <= collide | (wcol_q & ~clr_wcol);
      end
   end

   assign rdata = buf_q;
   assign full  = full_q;
   assign ovf   = ovf_q;
   assign wcol  = wcol_q;
   assign irq   = irq_q;
endmodule

// File: rtl/spi_xfer_port.sv
module spi_xfer_port #(
   parameter int unsigned W           = 8,
   parameter int unsigned BASE_HALF   = 2,
   parameter int unsigned STEP_LOG2   = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         cfg_master,
   input  logic         cfg_cpol,
   input  logic         cfg_cpha,
   input  logic         cfg_smp_end,
   input  logic [1:0]   cfg_rate,
   input  logic         cfg_sel_en,
   input  logic         host_wr,
   input  logic [W-1:0] host_wdata,
   input  logic         host_rd,
   output logic [W-1:0] host_rdata,
   input  logic         clr_wcol,
   input  logic         clr_ovf,
   input  logic         clr_irq,
   output logic         st_busy,
   output logic         st_full,
   output logic         st_wcol,
   output logic         st_ovf,
   output logic         irq,
   input  logic         sck_i,
   output logic         sck_o,
   output logic         sck_oe,
   input  logic         sdi,
   output logic         sdo,
   output logic         sdo_oe,
   input  logic         sel_n
);
   import spi_port_pkg::*;

   localparam int unsigned K_W  = $clog2(2 * W + 1);
   localparam int unsigned NSIG = 3;
   localparam logic [K_W-1:0] B_LAST = K_W'(2 * W);
   localparam logic [K_W-1:0] B_TWO  = K_W'(2);

   if (W < 2) begin : g_bad_w
      $error("spi_xfer_port: W must be at least 2");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("spi_xfer_port: SYNC_STAGES must be at least 1");
   end

   // ---------------- input synchronizers (slave side) ----------------
   logic [NSIG-1:0] raw_in, rst_val, synced;
   logic [SYNC_STAGES-1:0][NSIG-1:0] stage_q;

   assign raw_in  = {sel_n, sdi, sck_i};
   assign rst_val = {1'b1, 1'b0, cfg_cpol};

   if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
         stage_q <= rst ? rst_val : raw_in;
      end
   end else begin : g_syncn
      always_ff @(posedge clk) begin
         if (rst) stage_q <= {SYNC_STAGES{rst_val}};
         else     stage_q <= {stage_q[SYNC_STAGES-2:0], raw_in};
      end
   end
   assign synced = stage_q[SYNC_STAGES-1];

   logic sck_s, sdi_s, sel_s, sck_p;
   assign sck_s = synced[0];
   assign sdi_s = synced[1];
   assign sel_s = synced[2];

   always_ff @(posedge clk) begin
      if (rst) sck_p <= cfg_cpol;
      else     sck_p <= sck_s;
   end

   // ---------------- sequencer ----------------
   logic [K_W-1:0] k_q, bnd;
   logic           busy_q, selected, start, load, tick, step, sck_edge, xfer_done;
   bit_ev_t        ev;

   assign selected = !(cfg_sel_en && sel_s);
   assign sck_edge = (sck_s != sck_p) && selected;
   assign load     = host_wr && !busy_q;
   assign start    = cfg_master && load;
   assign step     = cfg_master ? tick : sck_edge;

   always_comb begin
      if (cfg_master || !cfg_cpha) bnd = k_q + K_W'(1);
      else                         bnd = k_q;
      ev.last  = step && ((bnd == B_LAST) ||
                          (!cfg_master && cfg_cpha && (bnd == B_LAST - K_W'(1))));
      ev.shift = (step && !bnd[0] && (bnd >= B_TWO)) || ev.last;
      if (bnd[0]) ev.cap = step && !(cfg_master && cfg_smp_end);
      else        ev.cap = step && cfg_master && cfg_smp_end && (bnd >= B_TWO);
   end
   assign xfer_done = ev.last;

   always_ff @(posedge clk) begin
      if (rst) begin
         k_q    <= '0;
         busy_q <= 1'b0;
      end else if (cfg_master) begin
         if (start) begin
            k_q    <= '0;
            busy_q <= 1'b1;
         end else if (tick) begin
            k_q    <= ev.last ? '0 : k_q + K_W'(1);
            busy_q <= !ev.last;
         end
      end else if (!selected) begin
         k_q    <= '0;
         busy_q <= 1'b0;
      end else if (sck_edge) begin
         k_q    <= ev.last ? '0 : k_q + K_W'(1);
         busy_q <= !ev.last;
      end
   end

   spi_sck_div #(.BASE_HALF(BASE_HALF), .STEP_LOG2(STEP_LOG2)) u_div (
      .clk     (clk),
      .rst     (rst),
      .restart (start),
      .run     (busy_q && cfg_master),
      .sel     (cfg_rate),
      .tick    (tick)
   );

   logic [W-1:0] word;

   spi_shift_core #(.W(W)) u_shift (
      .clk       (clk),
      .rst       (rst),
      .load      (load),
      .load_data (host_wdata),
      .ev        (ev),
      .in_bit    (cfg_master ? sdi : sdi_s),
      .out_bit   (sdo),
      .word_out  (word)
   );

   spi_rx_hold #(.W(W)) u_hold (
      .clk      (clk),
      .rst      (rst),
      .done     (xfer_done),
      .word_in  (word),
      .rd       (host_rd),
      .collide  (host_wr && busy_q),
      .clr_wcol (clr_wcol),
      .clr_ovf  (clr_ovf),
      .clr_irq  (clr_irq),
      .rdata    (host_rdata),
      .full     (st_full),
      .ovf      (st_ovf),
      .wcol     (st_wcol),
      .irq      (irq)
   );

   assign sck_o   = cfg_cpol ^ (busy_q && cfg_master && (cfg_cpha ? ~k_q[0] : k_q[0]));
   assign sck_oe  = cfg_master;
   assign sdo_oe  = cfg_master || selected;
   assign st_busy = busy_q;
endmodule

// File: rtl/spi_xfer_port_chk.sv
module spi_xfer_port_chk #(
   parameter int unsigned W = 8
) (
   input logic         clk,
   input logic         rst,
   input logic         busy,
   input logic         wr,
   input logic         wcol,
   input logic         clr_wcol,
   input logic         rd,
   input logic         full,
   input logic         done,
   input logic         irq,
   input logic [W-1:0] rdata,
   input logic         master,
   input logic         cpol,
   input logic         sck
);
   // R7: a write during a transfer raises the collision flag
   a_r7_wcol_set: assert property (@(posedge clk) disable iff (rst)
      (wr && busy) |=> wcol);

   // R7: the collision flag holds until software clears it
   a_r7_wcol_sticky: assert property (@(posedge clk) disable iff (rst)
      (wcol && !clr_wcol) |=> wcol);

   // R5: a read with no byte arriving empties the holding register
   a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
      (rd && !done) |=> !full);

   // R4: completion raises full and the interrupt request
   a_r4_done_sets: assert property (@(posedge clk) disable iff (rst)
      done |=> (full && irq));

   // R8: an unread byte is never overwritten
   a_r8_no_overwrite: assert property (@(posedge clk) disable iff (rst)
      (full && !rd) |=> $stable(rdata));

   // R3: the master clock rests at its idle level between bytes
   a_r3_idle_level: assert property (@(posedge clk) disable iff (rst)
      (master && !busy) |-> (sck == cpol));
endmodule

bind spi_xfer_port spi_xfer_port_chk #(.W(W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .busy     (st_busy),
   .wr       (host_wr),
   .wcol     (st_wcol),
   .clr_wcol (clr_wcol),
   .rd       (host_rd),
   .full     (st_full),
   .done     (xfer_done),
   .irq      (irq),
   .rdata    (host_rdata),
   .master   (cfg_master),
   .cpol     (cfg_cpol),
   .sck      (sck_o)
);

// File: tb/spi_xfer_port_tb.sv
module spi_xfer_port_tb;
   logic       clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst = 1'b1;
   logic       cfg_master = 1'b1, cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_smp_end = 1'b0;
   logic [1:0] cfg_rate = 2'd0;
   logic       cfg_sel_en = 1'b0;
   logic       host_wr = 1'b0, host_rd = 1'b0;
   logic [7:0] host_wdata = 8'h00;
   logic [7:0] host_rdata;
   logic       clr_wcol = 1'b0, clr_ovf = 1'b0, clr_irq = 1'b0;
   logic       st_busy, st_full, st_wcol, st_ovf, irq;
   logic       sck_i = 1'b0, sck_o, sck_oe;
   logic       sdi, sdo, sdo_oe;
   logic       sel_n = 1'b1;
   logic       loop_en = 1'b1, sdi_drv = 1'b0;

   assign sdi = loop_en ? sdo : sdi_drv;

   int n_chk = 0;
   int n_err = 0;

   spi_xfer_port u_dut (
      .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
      .cfg_cpha(cfg_cpha), .cfg_smp_end(cfg_smp_end), .cfg_rate(cfg_rate),
      .cfg_sel_en(cfg_sel_en), .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rd(host_rd), .host_rdata(host_rdata), .clr_wcol(clr_wcol),
      .clr_ovf(clr_ovf), .clr_irq(clr_irq), .st_busy(st_busy), .st_full(st_full),
      .st_wcol(st_wcol), .st_ovf(st_ovf), .irq(irq), .sck_i(sck_i), .sck_o(sck_o),
      .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .sel_n(sel_n)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(input logic m, input logic pol, input logic pha,
                           input logic smp, input logic [1:0] rate, input logic sel_en);
      cfg_master = m; cfg_cpol = pol; cfg_cpha = pha; cfg_smp_end = smp;
      cfg_rate = rate; cfg_sel_en = sel_en;
      sck_i = pol; sel_n = 1'b1; sdi_drv = 1'b0; loop_en = m;
      host_wr = 1'b0; host_rd = 1'b0; clr_wcol = 1'b0; clr_ovf = 1'b0; clr_irq = 1'b0;
      rst = 1'b1;
      wait_neg(3);
      rst = 1'b0;
      wait_neg(1);
   endtask

   task automatic host_pulse(input logic [7:0] d);
      @(negedge clk); host_wr = 1'b1; host_wdata = d;
      @(negedge clk); host_wr = 1'b0;
   endtask

   task automatic rd_pulse();
      @(negedge clk); host_rd = 1'b1;
      @(negedge clk); host_rd = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 20000 && st_busy; i++) @(negedge clk);
   endtask

   // Master byte with exact timing and clock-shape checks
   task automatic m_run(input logic [7:0] tx, input int half);
      int   edges;
      logic prev;
      edges = 0;
      prev  = cfg_cpol;
      host_pulse(tx);                       // now half a cycle after the write edge
      chk("R3", "first sck level", int'(sck_o), int'(cfg_cpha ? !cfg_cpol : cfg_cpol));
      chk("R2", "busy after write", int'(st_busy), 1);
      if (sck_o != prev) edges++;
      prev = sck_o;
      for (int i = 1; i < 16 * half; i++) begin
         @(negedge clk);
         if (sck_o != prev) edges++;
         prev = sck_o;
      end
      chk("R2", "busy just before end", int'(st_busy), 1);
      @(negedge clk);
      if (sck_o != prev) edges++;
      chk("R2", "busy at end", int'(st_busy), 0);
      chk("R3", "sck transitions", edges, 16);
      chk("R3", "sck back to idle", int'(sck_o), int'(cfg_cpol));
   endtask

   task automatic sck_pulse();
      sck_i = ~cfg_cpol; wait_neg(8);
      sck_i = cfg_cpol;  wait_neg(8);
   endtask

   // External master model driving the slave port
   task automatic s_run(input logic [7:0] tx, input logic [7:0] md, output logic [7:0] got);
      host_pulse(tx);
      sel_n = 1'b0;
      wait_neg(8);
      for (int b = 7; b >= 0; b--) begin
         if (!cfg_cpha) begin
            sdi_drv = md[b]; wait_neg(8);
            got[b]  = sdo;
            sck_i   = ~cfg_cpol; wait_neg(8);
            sck_i   = cfg_cpol;
         end else begin
            sck_i   = ~cfg_cpol; sdi_drv = md[b]; wait_neg(8);
            got[b]  = sdo;
            sck_i   = cfg_cpol; wait_neg(8);
         end
      end
      wait_neg(8);
      sel_n = 1'b1;
      wait_neg(4);
   endtask

   task automatic t_reset();
      do_reset(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0);
      chk("R3", "idle sck after reset", int'(sck_o), 1);
      chk("R12", "busy after reset", int'(st_busy), 0);
      chk("R12", "full after reset", int'(st_full), 0);
      chk("R12", "wcol after reset", int'(st_wcol), 0);
      chk("R12", "ovf after reset", int'(st_ovf), 0);
      chk("R12", "irq after reset", int'(irq), 0);
   endtask

   task automatic t_master_basic();
      do_reset(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
      m_run(8'hA5, 2);
      chk("R1", "looped byte", int'(host_rdata), 8'hA5);
      chk("R4", "full on done", int'(st_full), 1);
      chk("R4", "irq on done", int'(irq), 1);
      rd_pulse();
      chk("R5", "full after read", int'(st_full), 0);
      chk("R9", "irq kept by read", int'(irq), 1);
      host_pulse(8'h0F);
      wait_idle();
      @(negedge clk); clr_irq = 1'b1;
      @(negedge clk); clr_irq = 1'b0;
      chk("R9", "irq cleared", int'(irq), 0);
      chk("R9", "full kept by irq clear", int'(st_full), 1);
   endtask

   task automatic t_master_modes();
      do_reset(1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 1'b0);
      m_run(8'h3C, 8);
      chk("R1", "cpha1 cpol1 rate1 byte", int'(host_rdata), 8'h3C);
      do_reset(1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0);
      m_run(8'h81, 2);
      chk("R1", "end-sample byte", int'(host_rdata), 8'h81);
      do_reset(1'b1, 1'b0, 1'b1, 1'b1, 2'd2, 1'b0);
      m_run(8'h5E, 32);
      chk("R1", "cpha1 end-sample rate2 byte", int'(host_rdata), 8'h5E);
   endtask

   task automatic t_collision();
      do_reset(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
      host_pulse(8'hC3);
      wait_neg(3);
      host_pulse(8'h18);
      chk("R7", "wcol set", int'(st_wcol), 1);
      wait_idle();
      chk("R7", "byte in flight kept", int'(host_rdata), 8'hC3);
      chk("R7", "wcol still set", int'(st_wcol), 1);
      @(negedge clk); clr_wcol = 1'b1;
      @(negedge clk); clr_wcol = 1'b0;
      chk("R7", "wcol cleared", int'(st_wcol), 0);
      host_pulse(8'h77);
      chk("R7", "idle write accepted", int'(st_busy), 1);
      chk("R7", "no collision when idle", int'(st_wcol), 0);
      wait_idle();
   endtask

   task automatic t_double();
      do_reset(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
      m_run(8'h11, 2);
      host_pulse(8'h22);
      chk("R6", "start while full", int'(st_busy), 1);
      chk("R6", "old byte readable", int'(host_rdata), 8'h11);
      rd_pulse();
      chk("R6", "full cleared mid-transfer", int'(st_full), 0);
      wait_idle();
      chk("R6", "new byte landed", int'(host_rdata), 8'h22);
      chk("R6", "no overrun", int'(st_ovf), 0);
   endtask

   task automatic t_overflow();
      do_reset(1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0);
      m_run(8'h6B, 2);
      m_run(8'h94, 2);
      chk("R8", "overrun set", int'(st_ovf), 1);
      chk("R8", "held byte kept", int'(host_rdata), 8'h6B);
      rd_pulse();
      chk("R8", "overrun kept by read", int'(st_ovf), 1);
      @(negedge clk); clr_ovf = 1'b1;
      @(negedge clk); clr_ovf = 1'b0;
      chk("R8", "overrun cleared", int'(st_ovf), 0);
   endtask

   task automatic t_slave();
      logic [7:0] got;
      do_reset(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
      s_run(8'hC5, 8'h3A, got);
      chk("R10", "phase0 slave sent", int'(got), 8'hC5);
      chk("R10", "phase0 slave received", int'(host_rdata), 8'h3A);
      chk("R10", "phase0 full", int'(st_full), 1);
      do_reset(1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0);
      s_run(8'h69, 8'hB2, got);
      chk("R10", "phase1 slave sent", int'(got), 8'h69);
      chk("R10", "phase1 slave received", int'(host_rdata), 8'hB2);
   endtask

   task automatic t_select();
      logic [7:0] got;
      do_reset(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1);
      chk("R11", "sdo off when deselected", int'(sdo_oe), 0);
      for (int i = 0; i < 4; i++) sck_pulse();
      chk("R11", "edges ignored busy", int'(st_busy), 0);
      chk("R11", "edges ignored full", int'(st_full), 0);
      sel_n = 1'b0; wait_neg(4);
      chk("R11", "sdo on when selected", int'(sdo_oe), 1);
      for (int i = 0; i < 3; i++) sck_pulse();
      chk("R11", "partial byte busy", int'(st_busy), 1);
      sel_n = 1'b1; wait_neg(4);
      chk("R11", "deselect aborts", int'(st_busy), 0);
      s_run(8'hE7, 8'h18, got);
      chk("R11", "fresh byte sent", int'(got), 8'hE7);
      chk("R11", "fresh byte received", int'(host_rdata), 8'h18);
      chk("R11", "no collision after abort", int'(st_wcol), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      t_reset();
      t_master_basic();
      t_master_modes();
      t_collision();
      t_double();
      t_overflow();
      t_slave();
      t_select();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule